// File: doc/BRIEF.md
# Serial Arbitration Interrupt Controller

This block is the host end of a shared interrupt bus. Any number of devices share one request line and one arbitration line, all clocked from the same source as the controller. When the request line goes high while the controller is idle, the controller raises a sync strobe. This tells every requesting device to join a bit-serial contest on the arbitration line. On that line a driven one overrides a driven zero, as in a wired-OR.

The contest runs in slots of one clock each. In the first slot, the type slot, each contender drives the inverse of its DMA wish. A CPU interrupt request therefore beats any DMA request. The controller then steps a bit index from 0 to 7. Each contender drives the selected bit of its 8-bit channel number, where index 0 selects the most significant bit. A contender that drives a zero while the line reads one drops out. The controller records the line in every slot. After the last slot it presents the channel number of the surviving device and a CPU-interrupt/DMA flag, and pulses a done strobe for one cycle. It then waits for the request line to fall before it can start another contest.

Top module: `sarb_irq_ctrl`

## Requirements
- R1: A synchronous active-high reset, whether applied in idle or in the middle of a contest, leaves `arb_sync_o` low, `bit_idx_o` at 0 and `done_o` low in the cycle after the reset edge.
- R2: If `req_i` is high while the controller is idle, `arb_sync_o` and `type_slot_o` are both high in the next cycle. `type_slot_o` stays high for exactly that one cycle.
- R3: After the type slot, `arb_sync_o` stays high for eight more cycles. During those cycles `bit_idx_o` counts 0, 1, 2 … 7, one step per cycle.
- R4: The line value sampled while `bit_idx_o` equals k is stored in bit 7−k of `vec_o`, so index 0 fills the most significant bit and index 7 fills the least significant bit.
- R5: Among contenders of the same request type, the one with the highest channel number is reported in `vec_o`.
- R6: `irq_o` is 1 when the line was high during the type slot (a CPU interrupt won) and 0 when it was low (DMA). Any CPU interrupt request is reported ahead of every DMA request, whatever the channel numbers.
- R7: `done_o` is a single-cycle pulse. It is first high 9 cycles after `arb_sync_o` rises, which is within 10 cycles, and `arb_sync_o` is low while `done_o` is high.
- R8: `vec_o` and `irq_o` change only in the cycle where `done_o` is high, and they hold their value until the next done pulse.
- R9: After a done pulse, no new contest starts while `req_i` stays high. A contest can start only after `req_i` has been seen low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Common clock for the controller and the devices |
| rst | input | 1 | Synchronous reset, active high |
| req_i | input | 1 | Shared request line, the OR of all device requests |
| arb_line_i | input | 1 | Shared arbitration line, the OR of all contender drives |
| arb_sync_o | output | 1 | High for the whole contest (type slot plus eight address slots) |
| type_slot_o | output | 1 | High in the type slot, when devices drive the inverse of their DMA wish |
| bit_idx_o | output | 3 | Address bit the devices drive; 0 is the most significant bit |
| vec_o | output | 8 | Channel number of the last winner |
| irq_o | output | 1 | 1 = last winner requested a CPU interrupt, 0 = DMA |
| done_o | output | 1 | One-cycle pulse when a new result is in `vec_o` and `irq_o` |

## Verification
The outcome depends on contenders dropping out slot by slot, and that behaviour cannot be reached by driving the arbitration line directly. For this reason the bench models each device as a small contender that drives its type bit and then its address bits. Each device model drops out as soon as it loses a slot, and the arbitration line is resolved as the OR of the device drives.

The hardest cases are contests where the type slot overrules the address. One such case is a low-numbered CPU interrupt against a high-numbered DMA request. Another is a set of channels that agree on their upper bits and differ only near the least significant bit. The bench builds these cases on purpose and also runs a computed sweep of mixed patterns. It holds the request line high after a done pulse to show that no second contest starts, and it applies reset in the middle of a contest.

// File: rtl/sarb_pkg.sv
package sarb_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_TYPE = 2'd1,
        ST_ADDR = 2'd2,
        ST_HOLD = 2'd3
    } sarb_state_e;

    function automatic int unsigned idx_width(input int unsigned vec_w);
        return (vec_w > 1) ? $clog2(vec_w) : 1;
    endfunction

endpackage

// File: rtl/sarb_seq.sv
module sarb_seq
    import sarb_pkg::*;
#(
    parameter int unsigned VEC_W = 8,
    localparam int unsigned IDX_W = idx_width(VEC_W)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_i,
    output logic             sync_o,
    output logic             tslot_o,
    output logic [IDX_W-1:0] idx_o,
    output logic             shift_o,
    output logic             last_o,
    output logic             done_o
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(VEC_W - 1);

    typedef struct packed {
        sarb_state_e      state;
        logic [IDX_W-1:0] idx;
        logic             sync;
        logic             tslot;
        logic             done;
    } seq_t;

    seq_t s_d, s_q;

    // Next-state logic for the contest sequence: type slot, address slots, hold.
    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        unique case (s_q.state)
            ST_IDLE: begin
                if (req_i) begin
                    s_d.state = ST_TYPE;
                    s_d.sync  = 1'b1;
                    s_d.tslot = 1'b1;
                    s_d.idx   = '0;
                end
            end
            ST_TYPE: begin
                s_d.state = ST_ADDR;
                s_d.tslot = 1'b0;
                s_d.idx   = '0;
            end
            ST_ADDR: begin
                if (s_q.idx == LAST_IDX) begin
                    s_d.state = ST_HOLD;
                    s_d.sync  = 1'b0;
                    s_d.done  = 1'b1;
                    s_d.idx   = '0;
                end else begin
                    s_d.idx = s_q.idx + 1'b1;
                end
            end
            ST_HOLD: begin
                if (!req_i) begin
                    s_d.state = ST_IDLE;
                end
            end
            default: s_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q.state <= ST_IDLE;
            s_q.idx   <= '0;
            s_q.sync  <= 1'b0;
            s_q.tslot <= 1'b0;
            s_q.done  <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign sync_o  = s_q.sync;
    assign tslot_o = s_q.tslot;
    assign idx_o   = s_q.idx;
    assign done_o  = s_q.done;
    assign shift_o = (s_q.state == ST_ADDR);
    assign last_o  = (s_q.state == ST_ADDR) && (s_q.idx == LAST_IDX);

endmodule

// File: rtl/sarb_shift.sv
module sarb_shift #(
    parameter int unsigned VEC_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             line_i,
    input  logic             type_en_i,
    input  logic             shift_en_i,
    input  logic             last_i,
    output logic [VEC_W-1:0] vec_o,
    output logic             irq_o
);

    typedef struct packed {
        logic [VEC_W-1:0] work;
        logic             type_w;
        logic [VEC_W-1:0] vec;
        logic             irq;
    } shf_t;

    shf_t h_d, h_q;
    logic [VEC_W-1:0] shifted;

    // The first address slot lands in the MSB; each later slot pushes it up one place.
    generate
        if (VEC_W > 1) begin : g_wide
            assign shifted = {h_q.work[VEC_W-2:0], line_i};
        end else begin : g_narrow
            assign shifted = line_i;
        end
    endgenerate

    always_comb begin
        h_d = h_q;
        if (type_en_i) begin
            h_d.type_w = line_i;
            h_d.work   = '0;
        end
        if (shift_en_i) begin
            h_d.work = shifted;
        end
        if (last_i) begin
            h_d.vec = shifted;
            h_d.irq = h_q.type_w;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            h_q <= '0;
        end else begin
            h_q <= h_d;
        end
    end

    assign vec_o = h_q.vec;
    assign irq_o = h_q.irq;

endmodule

// File: rtl/sarb_irq_ctrl.sv
module sarb_irq_ctrl
    import sarb_pkg::*;
#(
    parameter int unsigned VEC_W = 8,
    localparam int unsigned IDX_W = idx_width(VEC_W)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_i,
    input  logic             arb_line_i,
    output logic             arb_sync_o,
    output logic             type_slot_o,
    output logic [IDX_W-1:0] bit_idx_o,
    output logic [VEC_W-1:0] vec_o,
    output logic             irq_o,
    output logic             done_o
);

    logic shift_en;
    logic last_slot;

    sarb_seq #(.VEC_W(VEC_W)) u_seq (
        .clk     (clk),
        .rst     (rst),
        .req_i   (req_i),
        .sync_o  (arb_sync_o),
        .tslot_o (type_slot_o),
        .idx_o   (bit_idx_o),
        .shift_o (shift_en),
        .last_o  (last_slot),
        .done_o  (done_o)
    );

    sarb_shift #(.VEC_W(VEC_W)) u_shift (
        .clk        (clk),
        .rst        (rst),
        .line_i     (arb_line_i),
        .type_en_i  (type_slot_o),
        .shift_en_i (shift_en),
        .last_i     (last_slot),
        .vec_o      (vec_o),
        .irq_o      (irq_o)
    );

endmodule

// File: rtl/sarb_irq_ctrl_chk.sv
module sarb_irq_ctrl_chk #(
    parameter int unsigned VEC_W = 8,
    parameter int unsigned IDX_W = 3
) (
    input logic             clk,
    input logic             rst,
    input logic             req_i,
    input logic             arb_line_i,
    input logic             arb_sync_o,
    input logic             type_slot_o,
    input logic [IDX_W-1:0] bit_idx_o,
    input logic [VEC_W-1:0] vec_o,
    input logic             irq_o,
    input logic             done_o
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(VEC_W - 1);

    // R1: reset clears the contest outputs
    a_r1_reset_idle: assert property (@(posedge clk)
        rst |=> (!arb_sync_o && bit_idx_o == '0 && !done_o));

    // R2: a contest begins with the type slot, which lasts one cycle
    a_r2_sync_opens_with_type: assert property (@(posedge clk) disable iff (rst)
        $rose(arb_sync_o) |-> type_slot_o);

    a_r2_type_one_cycle: assert property (@(posedge clk) disable iff (rst)
        type_slot_o |=> (!type_slot_o && arb_sync_o && bit_idx_o == '0));

    // R3: the index advances by one in each address slot
    a_r3_idx_step: assert property (@(posedge clk) disable iff (rst)
        (arb_sync_o && !type_slot_o && bit_idx_o != LAST_IDX)
            |=> (arb_sync_o && bit_idx_o == IDX_W'($past(bit_idx_o) + 1'b1)));

    // R4: the last address slot lands in the least significant bit
    a_r4_lsb_from_last_slot: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (vec_o[0] == $past(arb_line_i)));

    // R7: done is a single pulse with the strobe low
    a_r7_done_single: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    a_r7_done_sync_low: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !arb_sync_o);

    // R8: results change only together with done
    a_r8_result_stable: assert property (@(posedge clk) disable iff (rst)
        !done_o |-> ($stable(vec_o) && $stable(irq_o)));

    // R9: no restart while the request line is still high after done
    a_r9_no_restart: assert property (@(posedge clk) disable iff (rst)
        (done_o && req_i) |=> !arb_sync_o);

endmodule

bind sarb_irq_ctrl sarb_irq_ctrl_chk #(.VEC_W(VEC_W), .IDX_W(IDX_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .req_i       (req_i),
    .arb_line_i  (arb_line_i),
    .arb_sync_o  (arb_sync_o),
    .type_slot_o (type_slot_o),
    .bit_idx_o   (bit_idx_o),
    .vec_o       (vec_o),
    .irq_o       (irq_o),
    .done_o      (done_o)
);

// File: tb/sarb_irq_ctrl_bench.sv
module sarb_irq_ctrl_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NDEV       = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic [7:0] dev_ch  [NDEV];
    logic       dev_dma [NDEV];
    logic       dev_en  [NDEV];
    logic       dev_rq  [NDEV];
    logic       dev_in  [NDEV];
    logic       dev_drv [NDEV];

    logic       req_line, arb_line;
    logic       sync, tslot, irq, done;
    logic [2:0] idx;
    logic [7:0] vec;

    sarb_irq_ctrl u_sarb_irq_ctrl (
        .clk         (clk),
        .rst         (rst),
        .req_i       (req_line),
        .arb_line_i  (arb_line),
        .arb_sync_o  (sync),
        .type_slot_o (tslot),
        .bit_idx_o   (idx),
        .vec_o       (vec),
        .irq_o       (irq),
        .done_o      (done)
    );

    // Device models: drive the type bit, then one address bit per slot; drop out on loss.
    always_comb begin
        req_line = 1'b0;
        arb_line = 1'b0;
        for (int i = 0; i < NDEV; i++) begin
            dev_drv[i] = tslot ? ~dev_dma[i] : dev_ch[i][3'd7 - idx];
            req_line   = req_line | dev_rq[i];
            arb_line   = arb_line | (dev_in[i] & dev_drv[i]);
        end
    end

    always @(posedge clk) begin
        for (int i = 0; i < NDEV; i++) begin
            if (rst)                                        dev_in[i] <= 1'b0;
            else if (!sync)                                 dev_in[i] <= dev_rq[i];
            else if (dev_in[i] && !dev_drv[i] && arb_line)  dev_in[i] <= 1'b0;
        end
    end

    int n_tests = 0;
    int n_fail  = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    typedef struct packed { logic [7:0] v; logic irq; } exp_t;
    exp_t  exp_q[$];
    string tag_q[$];
    int    done_cnt = 0;
    int    cyc = 0;
    int    sync_start = 0;
    int    slot_k = 0;
    logic  sync_prev = 1'b0;

    // Monitor: slot order, done timing and scoreboard compare.
    always @(negedge clk) begin
        cyc++;
        if (!rst) begin
            if (sync && !sync_prev) sync_start = cyc;
            if (tslot) begin
                slot_k = 0;
            end else if (sync) begin
                check(idx == 3'(slot_k), "R3", "index in address slot", 32'(idx), 32'(slot_k));
                slot_k++;
            end
            if (done) begin
                exp_t  e;
                string t;
                done_cnt++;
                check(cyc - sync_start == 9, "R7", "cycles from sync to done",
                      32'(cyc - sync_start), 32'd9);
                if (exp_q.size() == 0) begin
                    check(1'b0, "R5", "unexpected done", 32'(vec), 32'd0);
                end else begin
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check(vec == e.v, t, "winning channel", 32'(vec), 32'(e.v));
                    check(irq == e.irq, "R6", "type flag", 32'(irq), 32'(e.irq));
                end
            end
        end
        sync_prev = sync;
    end

    task automatic set_dev(input int i, input logic [7:0] ch, input logic dma, input logic en);
        dev_ch[i] = ch; dev_dma[i] = dma; dev_en[i] = en;
    endtask

    task automatic clear_devs();
        for (int i = 0; i < NDEV; i++) set_dev(i, 8'h00, 1'b0, 1'b0);
    endtask

    // Driver: compute the expected winner, queue it, raise requests, wait, release.
    task automatic round(input string tag, input int hold);
        int   best = -1;
        logic best_irq = 1'b0;
        int   start;
        int   waited = 0;
        logic [7:0] held_v;
        logic held_i;
        for (int i = 0; i < NDEV; i++) begin
            if (dev_en[i]) begin
                if ((!dev_dma[i] && !best_irq) || ((!dev_dma[i]) == best_irq && int'(dev_ch[i]) > best)) begin
                    best = int'(dev_ch[i]);
                    best_irq = !dev_dma[i];
                end
            end
        end
        exp_q.push_back('{v: 8'(best), irq: best_irq});
        tag_q.push_back(tag);
        start = done_cnt;
        @(negedge clk);
        for (int i = 0; i < NDEV; i++) dev_rq[i] = dev_en[i];
        @(negedge clk);
        check(sync && tslot, "R2", "sync and type slot after request", {30'd0, sync, tslot}, 32'd3);
        @(negedge clk);
        check(sync && !tslot, "R2", "type slot lasts one cycle", {30'd0, sync, tslot}, 32'd2);
        while (done_cnt == start && waited < 40) begin
            @(posedge clk);
            waited++;
        end
        check(done_cnt != start, "R7", "done seen", 32'(done_cnt - start), 32'd1);
        held_v = vec; held_i = irq;
        for (int k = 0; k < hold; k++) begin
            @(negedge clk);
            check(!sync, "R9", "no restart with request held", 32'(sync), 32'd0);
            check(!done, "R7", "done is one cycle", 32'(done), 32'd0);
            check(vec == held_v && irq == held_i, "R8", "result held",
                  {23'd0, irq, vec}, {23'd0, held_i, held_v});
        end
        @(negedge clk);
        for (int i = 0; i < NDEV; i++) dev_rq[i] = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < NDEV; i++) dev_rq[i] = 1'b0;
        clear_devs();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check(!sync && idx == 3'd0 && !done, "R1", "reset state",
              {27'd0, sync, idx, done}, 32'd0);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        check(!sync, "R2", "no contest without request", 32'(sync), 32'd0);

        clear_devs(); set_dev(0, 8'h01, 1'b0, 1'b1);
        round("R5", 0);
        clear_devs(); set_dev(0, 8'h05, 1'b0, 1'b1);
        round("R4", 0);
        clear_devs(); set_dev(0, 8'h01, 1'b0, 1'b1); set_dev(1, 8'h05, 1'b0, 1'b1);
        round("R5", 4);
        clear_devs(); set_dev(0, 8'h02, 1'b0, 1'b1); set_dev(1, 8'hFE, 1'b1, 1'b1);
        round("R6", 0);
        clear_devs(); set_dev(0, 8'h10, 1'b1, 1'b1); set_dev(1, 8'h33, 1'b1, 1'b1);
        round("R6", 0);
        clear_devs(); set_dev(2, 8'h00, 1'b0, 1'b1);
        round("R4", 0);
        clear_devs(); set_dev(0, 8'hFF, 1'b1, 1'b1); set_dev(3, 8'h00, 1'b0, 1'b1);
        round("R6", 6);
        clear_devs(); set_dev(0, 8'h80, 1'b0, 1'b1); set_dev(1, 8'h7F, 1'b0, 1'b1);
        round("R5", 0);
        clear_devs(); set_dev(0, 8'hAA, 1'b0, 1'b1); set_dev(1, 8'hAB, 1'b0, 1'b1);
        set_dev(2, 8'hA9, 1'b0, 1'b1);
        round("R4", 0);

        for (int k = 0; k < 16; k++) begin
            clear_devs();
            for (int i = 0; i < NDEV; i++)
                set_dev(i, 8'((k * 37 + i * 53 + 11) & 255), 1'((k >> (i % 3)) & 1),
                        1'(((k + i) % 4) != 0));
            set_dev(0, dev_ch[0], dev_dma[0], 1'b1);
            round("R5", k % 3);
        end

        // R1: reset in the middle of a contest
        clear_devs(); set_dev(0, 8'h44, 1'b0, 1'b1);
        @(negedge clk);
        dev_rq[0] = 1'b1;
        repeat (4) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check(!sync && idx == 3'd0 && !done, "R1", "reset mid-contest",
              {27'd0, sync, idx, done}, 32'd0);
        dev_rq[0] = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        check(!sync, "R1", "idle after mid-contest reset", 32'(sync), 32'd0);

        clear_devs(); set_dev(1, 8'h3C, 1'b1, 1'b1);
        round("R5", 2);

        check(exp_q.size() == 0, "R7", "all expected results seen", 32'(exp_q.size()), 32'd0);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule